// File: doc/BRIEF.md
# UART host data-buffer and status unit

This unit connects a single-cycle register bus to the shift engines of a UART. One data address serves both directions: a bus write places a byte into a one-entry transmit holding buffer, and a bus read removes the oldest byte from a two-entry receive FIFO. The unit moves the held byte to the transmit shifter as soon as that shifter is idle and transmission is enabled. It accepts each received frame that the receive shifter reports with a strobe.

A status register reports four flags: receive data waiting, transmit finished, holding buffer empty and receive overrun. A control register holds the receiver and transmitter enables, three interrupt enables and the character size. Each interrupt request is its flag gated by its enable. The transmit-finished flag is cleared by an acknowledge input or by writing a one to its status bit.

Top module: `uart_hostbuf`

## Requirements
- R1: After reset, status (address 1) reads 0x04: the buffer-empty bit 2 is set and the receive bit 0, transmit-finished bit 1 and overrun bit 3 are clear. Control (address 2) reads 0, and all three interrupt requests are low.
- R2: A write to address 0 while the buffer-empty flag is set fills the holding buffer and clears that flag from the next cycle. A write while the flag is clear is dropped, and that byte is never handed to the shifter.
- R3: While the holding buffer is full, `tx_load` is high with the held byte on `tx_byte` in every cycle where `tx_idle` is high and the transmit enable (control bit 1) is set. The buffer-empty flag is set from the following cycle. With the transmit enable clear, no hand-over happens.
- R4: Address 0 reads return the received bytes oldest first, combinationally, while `bus_rd` is high. Each read strobe removes exactly one entry.
- R5: Status bit 0 is 1 exactly when the receive FIFO holds at least one unread byte.
- R6: While the receive enable (control bit 0) is clear, the FIFO is emptied and incoming frames are discarded, so status bit 0 reads 0.
- R7: A `tx_done` pulse with the holding buffer empty sets status bit 1. A `tx_done` pulse while the buffer is full leaves the bit clear. The bit is cleared by `irq_txc_ack` or by a status write with bit 1 set.
- R8: The character size sits in control bits 6:5, where code n means 5+n data bits. Bits above that size are cleared in a written byte before it is held, and in a received byte before it is stored.
- R9: A frame that arrives with both FIFO entries full, and with no read in the same cycle, is discarded, and sticky status bit 3 is set. Any address 0 read clears bit 3, and the stored entries are kept.
- R10: `irq_rxc`, `irq_dre` and `irq_txc` equal status bits 0, 2 and 1 gated by control bits 2, 3 and 4 respectively.
- R11: An address 0 read with the FIFO empty returns 0 and leaves the FIFO empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address: 0 data, 1 status, 2 control |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| rx_valid | input | 1 | Receive shifter has a complete frame |
| rx_data | input | DATA_W | Received frame data |
| tx_idle | input | 1 | Transmit shifter is empty |
| tx_done | input | 1 | Transmit shifter finished a frame |
| tx_load | output | 1 | Hand the held byte to the shifter |
| tx_byte | output | DATA_W | Byte being handed over |
| irq_txc_ack | input | 1 | Transmit-finished interrupt acknowledge |
| irq_rxc | output | 1 | Receive data interrupt request |
| irq_dre | output | 1 | Buffer-empty interrupt request |
| irq_txc | output | 1 | Transmit-finished interrupt request |

## Verification
The bench writes a second byte while the holding buffer is still full. A design that accepted that write would send the wrong byte or send an extra one, and the transmit scoreboard would flag it. A third frame sent into a full FIFO must leave the first two bytes in order and raise overrun. A design that overwrote an entry would return the wrong second byte, and a design that failed to clear the flag on read would still show bit 3 afterwards. Finished-frame pulses are given with the buffer empty and with it full, and the flag is cleared both by acknowledge and by write-one. Receive disable is checked by showing that stored bytes are lost and that later frames are ignored.

// File: rtl/uart_hb_pkg.sv
package uart_hb_pkg;
   typedef enum logic [1:0] {
      ADR_DATA = 2'd0,
      ADR_STAT = 2'd1,
      ADR_CTRL = 2'd2,
      ADR_NONE = 2'd3
   } adr_e;

   // status bit positions
   localparam int ST_RXC = 0;
   localparam int ST_TXC = 1;
   localparam int ST_DRE = 2;
   localparam int ST_OVR = 3;

   // control register layout, LSB first: rx_en, tx_en, ie_rxc, ie_dre, ie_txc, csz
   typedef struct packed {
      logic [1:0] csz;
      logic       ie_txc;
      logic       ie_dre;
      logic       ie_rxc;
      logic       tx_en;
      logic       rx_en;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/hb_char_mask.sv
module hb_char_mask #(
   parameter int DATA_W = 8
) (
   input  logic [1:0]        csz,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   localparam int ALWAYS_W = DATA_W - 3;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i < ALWAYS_W) begin : g_keep
         assign dout[i] = din[i];
      end else begin : g_gate
         localparam int NEED = i - ALWAYS_W + 1;
         assign dout[i] = din[i] & (csz >= 2'(NEED));
      end
   end
endmodule

// File: rtl/hb_rx_fifo.sv
module hb_rx_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 2,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic              pop,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic [CNT_W-1:0]  count,
   output logic              full,
   output logic              empty
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wp, rp;
   logic              do_push, do_pop;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign do_pop  = pop & ~empty;
   assign do_push = push & (~full | do_pop);
   assign dout    = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (flush) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) begin
            mem[wp] <= din;
            wp      <= wp + PTR_W'(1);
         end
         if (do_pop) rp <= rp + PTR_W'(1);
         count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
      end
   end
endmodule

// File: rtl/hb_tx_hold.sv
module hb_tx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] din,
   input  logic              launch_ok,
   output logic              load,
   output logic [DATA_W-1:0] dout,
   output logic              full
);
   assign load = full & launch_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         dout <= '0;
      end else if (load) begin
         full <= 1'b0;
      end else if (wr && !full) begin
         full <= 1'b1;
         dout <= din;
      end
   end
endmodule

// File: rtl/uart_hostbuf.sv
module uart_hostbuf
   import uart_hb_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int RX_DEPTH = 2,
   localparam int CNT_W   = $clog2(RX_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              tx_idle,
   input  logic              tx_done,
   output logic              tx_load,
   output logic [DATA_W-1:0] tx_byte,
   input  logic              irq_txc_ack,
   output logic              irq_rxc,
   output logic              irq_dre,
   output logic              irq_txc
);
   if (DATA_W < 8) begin : g_bad_width
      $error("uart_hostbuf: DATA_W must be at least 8");
   end
   if (RX_DEPTH < 2 || (RX_DEPTH & (RX_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("uart_hostbuf: RX_DEPTH must be a power of two, 2 or more");
   end

   ctrl_t             ctrl_q;
   logic              txc_q, ovr_q;
   logic              hold_full;
   logic [DATA_W-1:0] hold_q;
   logic [DATA_W-1:0] tx_masked, rx_masked, rx_head;
   logic [CNT_W-1:0]  rx_count;
   logic              rx_full, rx_empty;
   logic              wr_data, wr_stat, wr_ctrl, rd_data, rx_push;

   assign wr_data = bus_wr & (bus_addr == ADR_DATA);
   assign wr_stat = bus_wr & (bus_addr == ADR_STAT);
   assign wr_ctrl = bus_wr & (bus_addr == ADR_CTRL);
   assign rd_data = bus_rd & (bus_addr == ADR_DATA);
   assign rx_push = rx_valid & ctrl_q.rx_en;

   hb_char_mask #(.DATA_W(DATA_W)) u_tx_mask (
      .csz(ctrl_q.csz), .din(bus_wdata), .dout(tx_masked));

   hb_char_mask #(.DATA_W(DATA_W)) u_rx_mask (
      .csz(ctrl_q.csz), .din(rx_data), .dout(rx_masked));

   hb_tx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .wr(wr_data), .din(tx_masked),
      .launch_ok(ctrl_q.tx_en & tx_idle), .load(tx_load),
      .dout(hold_q), .full(hold_full));

   hb_rx_fifo #(.DATA_W(DATA_W), .DEPTH(RX_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(~ctrl_q.rx_en), .push(rx_push),
      .pop(rd_data), .din(rx_masked), .dout(rx_head), .count(rx_count),
      .full(rx_full), .empty(rx_empty));

   assign tx_byte = hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         txc_q  <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);

         if (tx_done && !hold_full)                        txc_q <= 1'b1;
         else if (irq_txc_ack || (wr_stat && bus_wdata[ST_TXC])) txc_q <= 1'b0;

         if (rx_push && rx_full && !rd_data) ovr_q <= 1'b1;
         else if (rd_data)                   ovr_q <= 1'b0;
      end
   end

   logic [3:0] status;
   always_comb begin
      status         = '0;
      status[ST_RXC] = ~rx_empty;
      status[ST_TXC] = txc_q;
      status[ST_DRE] = ~hold_full;
      status[ST_OVR] = ovr_q;
   end

   always_comb begin
      bus_rdata = '0;
      unique case (adr_e'(bus_addr))
         ADR_DATA: bus_rdata = rx_empty ? '0 : rx_head;
         ADR_STAT: bus_rdata = DATA_W'(status);
         ADR_CTRL: bus_rdata = DATA_W'(ctrl_q);
         default:  bus_rdata = '0;
      endcase
   end

   assign irq_rxc = status[ST_RXC] & ctrl_q.ie_rxc;
   assign irq_dre = status[ST_DRE] & ctrl_q.ie_dre;
   assign irq_txc = status[ST_TXC] & ctrl_q.ie_txc;
endmodule

// File: rtl/uart_hostbuf_chk.sv
module uart_hostbuf_chk #(
   parameter int DEPTH  = 2,
   parameter int CNT_W  = 2,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic              tx_load,
   input logic              tx_idle,
   input logic              tx_en,
   input logic              rx_en,
   input logic              rx_valid,
   input logic              hold_full,
   input logic [DATA_W-1:0] hold_q,
   input logic [CNT_W-1:0]  rx_count,
   input logic              ovr_q,
   input logic              txc_q,
   input logic              irq_txc
);
   logic data_adr;
   assign data_adr = (bus_addr == 2'd0);

   assert_load_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |-> (tx_idle && tx_en));

   assert_load_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |=> !hold_full);

   assert_full_write_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && data_adr && hold_full && !tx_load) |=> (hold_full && $stable(hold_q)));

   assert_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> (rx_count == '0));

   assert_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_en && rx_count == CNT_W'(DEPTH) && !(bus_rd && data_adr)) |=> ovr_q);

   assert_single_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && data_adr && rx_en && rx_count != '0 && !rx_valid)
         |=> (rx_count == $past(rx_count) - CNT_W'(1)));

   assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_txc |-> txc_q);
endmodule

bind uart_hostbuf uart_hostbuf_chk #(.DEPTH(RX_DEPTH), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .tx_load(tx_load), .tx_idle(tx_idle), .tx_en(ctrl_q.tx_en), .rx_en(ctrl_q.rx_en),
   .rx_valid(rx_valid), .hold_full(hold_full), .hold_q(hold_q), .rx_count(rx_count),
   .ovr_q(ovr_q), .txc_q(txc_q), .irq_txc(irq_txc));

// File: tb/uart_hostbuf_test.sv
module uart_hostbuf_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0, bus_rdata;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic       tx_idle = 1'b0, tx_done = 1'b0, tx_load;
   logic [7:0] tx_byte;
   logic       irq_txc_ack = 1'b0, irq_rxc, irq_dre, irq_txc;

   int checks = 0, errors = 0;
   logic [7:0] exp_tx[$];
   logic [7:0] exp_rx[$];
   logic       m_rxen = 0, m_txen = 0, m_dre = 1;
   logic [1:0] m_csz = 0;

   always #10 clk = ~clk;

   uart_hostbuf uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
      .tx_idle(tx_idle), .tx_done(tx_done), .tx_load(tx_load), .tx_byte(tx_byte),
      .irq_txc_ack(irq_txc_ack), .irq_rxc(irq_rxc), .irq_dre(irq_dre), .irq_txc(irq_txc));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] cmask(input logic [7:0] d, input logic [1:0] c);
      return d & 8'((9'd1 << (5 + c)) - 9'd1);
   endfunction

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk); bus_rd = 1'b0;
   endtask

   task automatic set_ctrl(input logic [7:0] v);
      m_rxen = v[0]; m_txen = v[1]; m_csz = v[6:5];
      if (!m_rxen) exp_rx.delete();
      bus_write(2'd2, v);
   endtask

   task automatic tx_write(input logic [7:0] d);
      if (m_dre) begin exp_tx.push_back(cmask(d, m_csz)); m_dre = 0; end
      bus_write(2'd0, d);
   endtask

   task automatic kick();
      @(negedge clk); tx_idle = 1'b1;
      @(negedge clk); tx_idle = 1'b0;
      if (m_txen) m_dre = 1;
   endtask

   task automatic frame(input logic [7:0] d);
      if (m_rxen && exp_rx.size() < 2) exp_rx.push_back(cmask(d, m_csz));
      @(negedge clk); rx_valid = 1'b1; rx_data = d;
      @(negedge clk); rx_valid = 1'b0;
   endtask

   task automatic pulse_done();
      @(negedge clk); tx_done = 1'b1;
      @(negedge clk); tx_done = 1'b0;
   endtask

   task automatic pulse_ack();
      @(negedge clk); irq_txc_ack = 1'b1;
      @(negedge clk); irq_txc_ack = 1'b0;
   endtask

   task automatic read_expect(input string req);
      logic [7:0] d, e;
      e = (exp_rx.size() == 0) ? 8'h00 : exp_rx.pop_front();
      bus_read(2'd0, d);
      chk(req, d, e);
   endtask

   task automatic stat_expect(input string req, input logic [7:0] e);
      logic [7:0] d;
      bus_read(2'd1, d);
      chk(req, d, e);
   endtask

   // scoreboard monitor for bytes handed to the transmit shifter
   initial begin
      forever begin
         @(negedge clk); #2;
         if (tx_load) begin
            checks++;
            if (exp_tx.size() == 0) begin
               errors++;
               $display("FAIL R2/R3 unexpected hand-over actual=%0h expected=none", tx_byte);
            end else begin
               logic [7:0] e;
               e = exp_tx.pop_front();
               if (tx_byte !== e) begin
                  errors++;
                  $display("FAIL R3 tx_byte actual=%0h expected=%0h", tx_byte, e);
               end
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      stat_expect("R1 status", 8'h04);
      bus_read(2'd2, d); chk("R1 control", d, 8'h00);
      chk("R1 irqs", {irq_rxc, irq_dre, irq_txc}, 3'b000);

      set_ctrl(8'h63);
      // R2 accepted write, then dropped write
      tx_write(8'hA5);
      stat_expect("R2 dre clear", 8'h00);
      tx_write(8'h11);
      kick();
      stat_expect("R3 dre set after hand-over", 8'h04);
      // R3 no hand-over with transmitter disabled
      set_ctrl(8'h61);
      tx_write(8'h3C);
      kick();
      stat_expect("R3 held while disabled", 8'h00);
      set_ctrl(8'h63);
      kick();
      // R7 transmit-finished
      pulse_done();
      stat_expect("R7 txc set", 8'h06);
      chk("R10 irq_txc off", irq_txc, 1'b0);
      set_ctrl(8'h73);
      chk("R10 irq_txc on", irq_txc, 1'b1);
      pulse_ack();
      stat_expect("R7 ack clears", 8'h04);
      chk("R10 irq_txc after ack", irq_txc, 1'b0);
      pulse_done();
      bus_write(2'd1, 8'h02);
      stat_expect("R7 w1c clears", 8'h04);
      tx_write(8'h77);
      pulse_done();
      stat_expect("R7 no set while full", 8'h00);
      kick();
      // R10 buffer-empty request
      set_ctrl(8'h6B);
      chk("R10 irq_dre empty", irq_dre, 1'b1);
      tx_write(8'h42);
      chk("R10 irq_dre full", irq_dre, 1'b0);
      kick();
      // R8 transmit masking at 5 bits
      set_ctrl(8'h03);
      tx_write(8'hFF);
      kick();
      // receive path
      set_ctrl(8'h67);
      stat_expect("R5 empty", 8'h04);
      chk("R10 irq_rxc off", irq_rxc, 1'b0);
      frame(8'h12);
      stat_expect("R5 data waiting", 8'h05);
      chk("R10 irq_rxc on", irq_rxc, 1'b1);
      frame(8'h34);
      frame(8'h56);
      stat_expect("R9 overrun set", 8'h0D);
      read_expect("R4 first byte");
      stat_expect("R9 overrun cleared by read", 8'h05);
      read_expect("R9 second byte kept");
      stat_expect("R5 empty after reads", 8'h04);
      read_expect("R11 empty read");
      stat_expect("R11 still empty", 8'h04);
      // R8 receive masking at 6 bits
      set_ctrl(8'h23);
      frame(8'hFF);
      read_expect("R8 rx mask");
      // R6 flush and ignore
      set_ctrl(8'h63);
      frame(8'h01);
      frame(8'h02);
      stat_expect("R5 two waiting", 8'h05);
      set_ctrl(8'h62);
      stat_expect("R6 flushed", 8'h04);
      frame(8'h09);
      set_ctrl(8'h63);
      stat_expect("R6 frame ignored", 8'h04);
      read_expect("R6 nothing stored");
      chk("R2 all queued bytes sent", exp_tx.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule